// File: doc/BRIEF.md
# Sticky Fault Register with Instruction Abort

This block collects hardware error indications into a 16-bit register whose bits, once set, stay set until software clears the whole register with a single command. Each error line is active low and is sampled on the rising clock edge. Some errors land in a different bit depending on whether the current bus cycle is an I/O cycle or a memory cycle, or whether a DMA transfer owns the bus. A bus-timeout pulse from a separate watchdog is treated like an address error.

The block turns the register into a level-1 machine-error request. The request is a one-cycle pulse that fires when the register becomes non-zero. It is then held off until the register has been seen empty, so a fault that stays latched cannot flood the processor with interrupts. Faults that must stop the running instruction (a processor protection error and the two address errors) also produce a one-cycle active-low abort strobe one edge after they are captured. While a DMA or hold acknowledge is active, those bits are not captured, no abort is issued and the illegal-address output stays high. Software reads the register at `fault_q`. Software can also clear it, or OR a bus word into it.

Top module: `fault_reg_unit`

## Requirements
- R1: After reset `fault_q` is 0x0000, `l1_req` is 0, and `abort_n` and `ill_addr_n` are 1.
- R2: A low level sampled at a rising edge sets a bit, visible on `fault_q` after that edge: `mem_par_n` sets bit 2, `io_par_n` bit 3, `dma_par_n` bit 4, `io_xfer_n` bit 6, `spare_n` bit 7, and `sys_fault_n` sets both bit 13 and bit 15. Every set bit stays set when its input returns high, and stays set through any command other than clear.
- R3: `addr_err_n` low or `bus_tmo` high sets bit 5 when `io_cycle`=1 and bit 8 when `io_cycle`=0. `prot_err_n` low sets bit 0 when no acknowledge is active, and bit 1 when `dma_ack`=1.
- R4: While `dma_ack` or `hold_ack` is 1, bits 0, 5 and 8 are not set by the error inputs, no abort is issued and `ill_addr_n` is 1. `prot_err_n` with only `hold_ack` active sets no bit.
- R5: With `cmd_valid`=1, code 0xA00F clears the whole register and code 0x8401 leaves it unchanged. Code 0x0401 ORs `bus_data` into the register, and so does `mc_load`=1. Any other code has no effect. Bits 9 to 12 always read 0.
- R6: When a clear and a new error are sampled at the same edge, the register holds only the new error's bits.
- R7: `l1_req` is high for exactly one cycle, starting right after the edge at which the register goes from all-zero to non-zero. After that it stays low, whatever new bits are set, until the register has been all-zero for at least one edge.
- R8: When an error input newly sets bit 0, 5 or 8 at edge k, `abort_n` is low from edge k+1 to edge k+2 and is never low for two cycles in a row. Bits set by a load command produce no abort.
- R9: `ill_addr_n` is 0 whenever bit 5 or bit 8 is set and neither acknowledge is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prot_err_n | input | 1 | Memory protection error, active low |
| mem_par_n | input | 1 | Memory parity error, active low |
| io_par_n | input | 1 | I/O parity error, active low |
| dma_par_n | input | 1 | DMA parity error, active low |
| addr_err_n | input | 1 | External address error, active low |
| io_xfer_n | input | 1 | I/O transfer error, active low |
| spare_n | input | 1 | User-defined spare error, active low |
| sys_fault_n | input | 1 | System self-test fault, active low |
| bus_tmo | input | 1 | Bus watchdog timeout, active high |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| dma_ack | input | 1 | DMA owns the bus |
| hold_ack | input | 1 | Processor is in hold |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 16 | Command code |
| mc_load | input | 1 | Microcode load of the register from the bus |
| bus_data | input | 16 | Data word for loads |
| fault_q | output | 16 | Register contents |
| l1_req | output | 1 | Level-1 request pulse |
| abort_n | output | 1 | Instruction abort strobe, active low |
| ill_addr_n | output | 1 | Illegal-address indication, active low |

## Verification
The bound checker watches several rules on every clock. Bits only fall on a clear command. The reserved bits stay zero. The level-1 pulse never lasts two cycles and never occurs with an empty register. The abort strobe is a single cycle. The illegal-address output stays high under either acknowledge. The bench covers what needs known stimulus. It sweeps every error input across both cycle types and all three acknowledge states and compares the captured mask with a computed value. It also runs the same-edge clear-and-error case, the held-off request after a second fault, and the effect of each command code.

// File: rtl/fault_pkg.sv
package fault_pkg;

    localparam int FW = 16;
    typedef logic [FW-1:0] fword_t;

    // bit positions decoded by neighbouring logic
    localparam int B_PROT_CPU = 0;
    localparam int B_PROT_DMA = 1;
    localparam int B_MEM_PAR  = 2;
    localparam int B_IO_PAR   = 3;
    localparam int B_DMA_PAR  = 4;
    localparam int B_IO_ADDR  = 5;
    localparam int B_IO_XFER  = 6;
    localparam int B_SPARE    = 7;
    localparam int B_MEM_ADDR = 8;
    localparam int B_ST_LO    = 13;
    localparam int B_ST_HI    = 15;

    localparam fword_t RSVD_MASK  = fword_t'(16'h1E00);
    localparam fword_t ADDR_MASK  = fword_t'((1 << B_IO_ADDR) | (1 << B_MEM_ADDR));
    localparam fword_t ABORT_MASK = fword_t'((1 << B_PROT_CPU) | ADDR_MASK);

    localparam logic [15:0] CODE_CLR_READ = 16'hA00F;
    localparam logic [15:0] CODE_PEEK     = 16'h8401;
    localparam logic [15:0] CODE_LOAD     = 16'h0401;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_PEEK,
        OP_CLEAR
    } fop_e;

    // error conditions, active high after input inversion
    typedef struct packed {
        logic prot;
        logic mem_par;
        logic io_par;
        logic dma_par;
        logic addr;
        logic io_xfer;
        logic spare;
        logic sys;
    } fin_t;

    function automatic fop_e decode_op(input logic valid, input logic [15:0] word);
        fop_e op;
        op = OP_NONE;
        if (valid) begin
            case (word)
                CODE_CLR_READ: op = OP_CLEAR;
                CODE_PEEK:     op = OP_PEEK;
                CODE_LOAD:     op = OP_LOAD;
                default:       op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/fault_route.sv
module fault_route
    import fault_pkg::*;
(
    input  fin_t   flt,
    input  logic   io_cycle,
    input  logic   dma_ack,
    input  logic   hold_ack,
    output fword_t set_vec
);
    logic blocked;
    assign blocked = dma_ack | hold_ack;

    always_comb begin
        set_vec             = '0;
        set_vec[B_PROT_CPU] = flt.prot & ~blocked;
        set_vec[B_PROT_DMA] = flt.prot & dma_ack;
        set_vec[B_MEM_PAR]  = flt.mem_par;
        set_vec[B_IO_PAR]   = flt.io_par;
        set_vec[B_DMA_PAR]  = flt.dma_par;
        set_vec[B_IO_ADDR]  = flt.addr & io_cycle & ~blocked;
        set_vec[B_MEM_ADDR] = flt.addr & ~io_cycle & ~blocked;
        set_vec[B_IO_XFER]  = flt.io_xfer;
        set_vec[B_SPARE]    = flt.spare;
        set_vec[B_ST_LO]    = flt.sys;
        set_vec[B_ST_HI]    = flt.sys;
    end
endmodule

// File: rtl/fault_cmd_dec.sv
module fault_cmd_dec
    import fault_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        mc_load,
    output logic        do_clear,
    output logic        do_load
);
    fop_e op;
    assign op       = decode_op(cmd_valid, cmd_word);
    assign do_clear = (op == OP_CLEAR);
    assign do_load  = (op == OP_LOAD) | mc_load;
endmodule

// File: rtl/fault_irq_gate.sv
module fault_irq_gate
    import fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fword_t fault_q,
    input  logic   abort_hit,
    input  logic   blocked,
    output logic   l1_req,
    output logic   abort_n
);
    logic armed_r;
    logic pend_r;
    logic abort_r;
    logic any_set;

    assign any_set = |fault_q;
    assign l1_req  = armed_r & any_set;
    assign abort_n = ~abort_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_r <= 1'b1;
            pend_r  <= 1'b0;
            abort_r <= 1'b0;
        end else begin
            if (!any_set)
                armed_r <= 1'b1;
            else if (l1_req)
                armed_r <= 1'b0;
            pend_r  <= abort_hit;
            abort_r <= pend_r & ~abort_r & ~blocked;
        end
    end
endmodule

// File: rtl/fault_reg_unit.sv
module fault_reg_unit
    import fault_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prot_err_n,
    input  logic        mem_par_n,
    input  logic        io_par_n,
    input  logic        dma_par_n,
    input  logic        addr_err_n,
    input  logic        io_xfer_n,
    input  logic        spare_n,
    input  logic        sys_fault_n,
    input  logic        bus_tmo,
    input  logic        io_cycle,
    input  logic        dma_ack,
    input  logic        hold_ack,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        mc_load,
    input  logic [15:0] bus_data,
    output logic [15:0] fault_q,
    output logic        l1_req,
    output logic        abort_n,
    output logic        ill_addr_n
);
    fin_t   fin;
    fword_t cap;
    fword_t fault_r;
    fword_t nxt;
    logic   do_clear;
    logic   do_load;
    logic   blocked;
    logic   abort_hit;

    assign fin.prot    = ~prot_err_n;
    assign fin.mem_par = ~mem_par_n;
    assign fin.io_par  = ~io_par_n;
    assign fin.dma_par = ~dma_par_n;
    assign fin.addr    = ~addr_err_n | bus_tmo;
    assign fin.io_xfer = ~io_xfer_n;
    assign fin.spare   = ~spare_n;
    assign fin.sys     = ~sys_fault_n;

    assign blocked = dma_ack | hold_ack;

    fault_route u_route (
        .flt      (fin),
        .io_cycle (io_cycle),
        .dma_ack  (dma_ack),
        .hold_ack (hold_ack),
        .set_vec  (cap)
    );

    fault_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .mc_load   (mc_load),
        .do_clear  (do_clear),
        .do_load   (do_load)
    );

    always_comb begin
        nxt = do_clear ? '0 : fault_r;
        nxt = nxt | cap;
        if (do_load)
            nxt = nxt | fword_t'(bus_data);
        nxt = nxt & ~RSVD_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault_r <= '0;
        else
            fault_r <= nxt;
    end

    assign abort_hit = |(cap & ~fault_r & ABORT_MASK);

    fault_irq_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .fault_q   (fault_r),
        .abort_hit (abort_hit),
        .blocked   (blocked),
        .l1_req    (l1_req),
        .abort_n   (abort_n)
    );

    assign fault_q    = fault_r;
    assign ill_addr_n = ~((|(fault_r & ADDR_MASK)) & ~blocked);
endmodule

// File: rtl/fault_reg_unit_chk.sv
module fault_reg_unit_chk
    import fault_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        dma_ack,
    input logic        hold_ack,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [15:0] fault_q,
    input logic        l1_req,
    input logic        abort_n,
    input logic        ill_addr_n
);
    AST_BITS_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_word == CODE_CLR_READ) |=> (($past(fault_q) & ~fault_q) == 16'h0)); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fault_q & RSVD_MASK) == 16'h0); // R5

    AST_L1_SINGLE: assert property (@(posedge clk) disable iff (rst)
        l1_req |=> !l1_req); // R7

    AST_L1_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        l1_req |-> (fault_q != 16'h0)); // R7

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !abort_n |=> abort_n); // R8

    AST_ACK_HOLDS_ILLADDR: assert property (@(posedge clk) disable iff (rst)
        (dma_ack || hold_ack) |-> ill_addr_n); // R4
endmodule

bind fault_reg_unit fault_reg_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_ack    (dma_ack),
    .hold_ack   (hold_ack),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .fault_q    (fault_q),
    .l1_req     (l1_req),
    .abort_n    (abort_n),
    .ill_addr_n (ill_addr_n)
);

// File: tb/fault_reg_unit_test.sv
module fault_reg_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  fl_n = 8'hFF;   // 0 prot,1 mempar,2 iopar,3 dmapar,4 addr,5 ioxfer,6 spare,7 sys
    logic        bus_tmo = 1'b0;
    logic        io_cycle = 1'b0;
    logic        dma_ack = 1'b0;
    logic        hold_ack = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = 16'h0;
    logic        mc_load = 1'b0;
    logic [15:0] bus_data = 16'h0;
    logic [15:0] fault_q;
    logic        l1_req;
    logic        abort_n;
    logic        ill_addr_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fault_reg_unit uut (
        .clk(clk), .rst(rst),
        .prot_err_n(fl_n[0]), .mem_par_n(fl_n[1]), .io_par_n(fl_n[2]),
        .dma_par_n(fl_n[3]), .addr_err_n(fl_n[4]), .io_xfer_n(fl_n[5]),
        .spare_n(fl_n[6]), .sys_fault_n(fl_n[7]), .bus_tmo(bus_tmo),
        .io_cycle(io_cycle), .dma_ack(dma_ack), .hold_ack(hold_ack),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .mc_load(mc_load),
        .bus_data(bus_data), .fault_q(fault_q), .l1_req(l1_req),
        .abort_n(abort_n), .ill_addr_n(ill_addr_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [15:0] code);
        cmd_valid = 1'b1;
        cmd_word  = code;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic clear_all();
        do_cmd(16'hA00F);
        tick();
    endtask

    function automatic logic [15:0] exp_mask(input int idx, input bit io, input int ack);
        logic [15:0] m;
        m = 16'h0;
        case (idx)
            0: m = (ack == 0) ? 16'h0001 : (ack == 1) ? 16'h0002 : 16'h0000;
            1: m = 16'h0004;
            2: m = 16'h0008;
            3: m = 16'h0010;
            4: m = (ack != 0) ? 16'h0000 : (io ? 16'h0020 : 16'h0100);
            5: m = 16'h0040;
            6: m = 16'h0080;
            default: m = 16'hA000;
        endcase
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] m;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 fault_q", fault_q, 16'h0);
        chk("R1 l1_req", {15'h0, l1_req}, 16'h0);
        chk("R1 abort_n", {15'h0, abort_n}, 16'h1);
        chk("R1 ill_addr_n", {15'h0, ill_addr_n}, 16'h1);

        // R2 R3 R4 R7 R8 R9: sweep inputs x cycle type x acknowledge
        for (int ack = 0; ack < 3; ack++) begin
            for (int io = 0; io < 2; io++) begin
                for (int idx = 0; idx < 8; idx++) begin
                    dma_ack  = (ack == 1);
                    hold_ack = (ack == 2);
                    io_cycle = io[0];
                    clear_all();
                    m = exp_mask(idx, io[0], ack);
                    fl_n[idx] = 1'b0;
                    tick();
                    fl_n[idx] = 1'b1;
                    chk("R2/R3/R4 capture", fault_q, m);
                    chk("R7 first request", {15'h0, l1_req}, {15'h0, (m != 0)});
                    chk("R9/R4 ill_addr_n", {15'h0, ill_addr_n},
                        {15'h0, !(((m & 16'h0120) != 0) && ack == 0)});
                    tick();
                    chk("R7 request ends", {15'h0, l1_req}, 16'h0);
                    chk("R8 abort low", {15'h0, abort_n}, {15'h0, !((m & 16'h0121) != 0)});
                    chk("R2 sticky", fault_q, m);
                    tick();
                    chk("R8 abort one cycle", {15'h0, abort_n}, 16'h1);
                end
            end
        end
        dma_ack  = 1'b0;
        hold_ack = 1'b0;

        // R3 bus timeout routing
        io_cycle = 1'b1;
        clear_all();
        bus_tmo = 1'b1; tick(); bus_tmo = 1'b0;
        chk("R3 timeout io", fault_q, 16'h0020);
        chk("R9 ill_addr_n low", {15'h0, ill_addr_n}, 16'h0);
        io_cycle = 1'b0;
        clear_all();
        bus_tmo = 1'b1; tick(); bus_tmo = 1'b0;
        chk("R3 timeout mem", fault_q, 16'h0100);
        tick();
        chk("R8 abort on timeout", {15'h0, abort_n}, 16'h0);

        // R7 anti-repeat: second fault while register nonempty
        fl_n[1] = 1'b0; tick(); fl_n[1] = 1'b1;
        chk("R7 second fault bits", fault_q, 16'h0104);
        chk("R7 no repeat request", {15'h0, l1_req}, 16'h0);

        // R6 clear and new fault at the same edge
        cmd_valid = 1'b1; cmd_word = 16'hA00F; fl_n[2] = 1'b0;
        tick();
        cmd_valid = 1'b0; fl_n[2] = 1'b1;
        chk("R6 new fault kept", fault_q, 16'h0008);
        chk("R6/R7 not rearmed", {15'h0, l1_req}, 16'h0);
        tick();
        chk("R7 still quiet", {15'h0, l1_req}, 16'h0);
        clear_all();
        fl_n[6] = 1'b0; tick(); fl_n[6] = 1'b1;
        chk("R7 rearmed after empty", {15'h0, l1_req}, 16'h1);

        // R5 commands
        clear_all();
        chk("R5 clear", fault_q, 16'h0);
        bus_data = 16'hFFFF;
        do_cmd(16'h0401);
        chk("R5 load OR masked", fault_q, 16'hE1FF);
        chk("R7 request on load", {15'h0, l1_req}, 16'h1);
        tick();
        chk("R8 no abort on load", {15'h0, abort_n}, 16'h1);
        tick();
        chk("R8 no abort on load later", {15'h0, abort_n}, 16'h1);
        do_cmd(16'h8401);
        chk("R5 peek keeps", fault_q, 16'hE1FF);
        do_cmd(16'h0400);
        chk("R5 other code ignored", fault_q, 16'hE1FF);
        bus_data = 16'h0000;
        mc_load = 1'b1; tick(); mc_load = 1'b0;
        chk("R5 load cannot clear", fault_q, 16'hE1FF);
        do_cmd(16'hA00F);
        chk("R5 read-clear", fault_q, 16'h0);
        bus_data = 16'h0004;
        mc_load = 1'b1; tick(); mc_load = 1'b0;
        chk("R5 microcode load", fault_q, 16'h0004);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule